// File: doc/BRIEF.md
# Wait/Hold Clock Divider with Deferred Ratio Update

This block derives a domain clock from a faster input clock by an integer ratio. Two count fields set the ratio. The wait count sets how many input cycles the output stays high, and the hold count sets how many it stays low. One output period is wait + hold + 2 input cycles. A bypass control routes the input clock straight to the output, and in that mode the counts have no effect.

A new ratio never takes effect in the middle of a period. Software places the new counts on the configuration inputs and pulses an update request. The block then raises a busy flag, which software polls. At the end of the low phase in progress, the divider latches the new counts, starts a high phase with them and drops the busy flag at that same edge. An enable input gates the divided output. When enable is removed, the current period still completes, and the output then stays low. A width parameter selects the normal 4-bit count fields or a reduced 3-bit variant.

Top module: `wh_clk_div`

## Requirements
- R1: After reset the output is low, the busy flag is low, and the active counts are wait = 0 and hold = 0, which is a ratio of 2.
- R2: With bypass off and enable high, the output is high for exactly wait+1 input cycles and then low for exactly hold+1 input cycles, so the period is wait+hold+2.
- R3: For a ratio R, programming wait = R/2-1 and hold = R-wait-2 gives a period of R. For odd R the high phase is one cycle shorter than the low phase.
- R4: Changing the count inputs without an update request has no effect on the output waveform.
- R5: The busy flag is high in the cycle after the update request is captured, unless that capture edge is itself a period end. Busy falls at the edge that ends the current low phase.
- R6: New counts apply only at a period end. The output is low in the last sample before busy falls, and the high phase that follows uses the new wait count.
- R7: When enable is low at the end of a low phase, the output stays low. The period in progress completes first. Once enable is high again, a high phase starts at the next edge.
- R8: With bypass set, the output follows the input clock while enable is high. Once a falling edge of the input clock sees enable low, the output is held low.
- R9: The count width CW sets the ratio range to 2..2^(CW+1). The default CW=4 reaches 32, and the reduced CW=3 variant reaches 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | CW | Requested high-phase count (high lasts cfg_wait+1 cycles) |
| cfg_hold | input | CW | Requested low-phase count (low lasts cfg_hold+1 cycles) |
| bypass | input | 1 | Route the input clock to the output |
| upd_req | input | 1 | One-cycle pulse that requests the configured counts be applied |
| enable | input | 1 | Gate for the domain output clock |
| clk_out | output | 1 | Divided, or bypassed, domain clock |
| upd_busy | output | 1 | High while an update request is pending |

## Verification
The bench builds two instances side by side. One uses the default CW=4 and reaches ratios up to 32. The other uses the reduced CW=3 variant, which tops out at 16, so the saturated all-ones count fields of both variants are measured. On both instances, random ratios across each full range sit alongside the minimum ratio 2, odd ratios that show the asymmetric phases, the handshake timing, gating and bypass.

// File: rtl/wh_div_pkg.sv
package wh_div_pkg;

    // Divider phase: parked low (disabled), high run, low run.
    typedef enum logic [1:0] {
        PH_PARK = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Largest ratio reachable with a count field of the given width.
    function automatic int unsigned max_ratio(input int unsigned cw);
        return 2 * (1 << cw);
    endfunction

    // Period in input cycles for given counts.
    function automatic int unsigned period_of(input int unsigned w, input int unsigned h);
        return w + h + 2;
    endfunction

endpackage

// File: rtl/wh_phase_gen.sv
module wh_phase_gen
    import wh_div_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] act_hi,
    input  logic [CW-1:0] act_lo,
    output logic          period_end,
    output logic          div_q
);

    phase_e        ph, ph_nx;
    logic [CW-1:0] cnt, cnt_nx;

    assign period_end = (ph == PH_PARK) || ((ph == PH_LOW) && (cnt == act_lo));

    always_comb begin
        ph_nx  = ph;
        cnt_nx = cnt + 1'b1;
        case (ph)
            PH_HIGH: begin
                if (cnt == act_hi) begin
                    ph_nx  = PH_LOW;
                    cnt_nx = '0;
                end
            end
            PH_LOW: begin
                if (cnt == act_lo) begin
                    ph_nx  = en ? PH_HIGH : PH_PARK;
                    cnt_nx = '0;
                end
            end
            default: begin
                ph_nx  = en ? PH_HIGH : PH_PARK;
                cnt_nx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_PARK;
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            ph    <= ph_nx;
            cnt   <= cnt_nx;
            div_q <= (ph_nx == PH_HIGH);
        end
    end

    assert_high_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HIGH) |-> (cnt <= act_hi));

    assert_low_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LOW) |-> (cnt <= act_lo));

    assert_disable_parks_low_R7: assert property (@(posedge clk) disable iff (rst)
        (period_end && !en) |=> !div_q);

    assert_rise_only_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> $past(period_end));

endmodule

// File: rtl/wh_update_ctl.sv
module wh_update_ctl #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_set,
    input  logic          period_end,
    input  logic [CW-1:0] cfg_hi,
    input  logic [CW-1:0] cfg_lo,
    output logic [CW-1:0] act_hi,
    output logic [CW-1:0] act_lo,
    output logic          busy
);

    logic load;

    assign load = period_end && (busy || upd_set);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_hi <= '0;
            act_lo <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            act_hi <= cfg_hi;
            act_lo <= cfg_lo;
            busy   <= 1'b0;
        end else if (upd_set) begin
            busy   <= 1'b1;
        end
    end

    assert_counts_hold_mid_period_R6: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> ($stable(act_hi) && $stable(act_lo)));

    assert_busy_clears_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(period_end));

    assert_busy_persists_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !period_end) |=> busy);

    assert_no_change_without_req_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !upd_set) |=> ($stable(act_hi) && $stable(act_lo)));

endmodule

// File: rtl/wh_bypass_gate.sv
module wh_bypass_gate (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic en,
    input  logic div_q,
    output logic clk_out
);

    // Enable captured while the input clock is low, so the AND never chops a high pulse.
    logic en_l;

    always_ff @(negedge clk) begin
        if (rst) en_l <= 1'b0;
        else     en_l <= en;
    end

    assign clk_out = bypass ? (clk & en_l) : div_q;

endmodule

// File: rtl/wh_clk_div.sv
module wh_clk_div
    import wh_div_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_hold,
    input  logic          bypass,
    input  logic          upd_req,
    input  logic          enable,
    output logic          clk_out,
    output logic          upd_busy
);

    logic [CW-1:0] act_hi, act_lo;
    logic          period_end;
    logic          div_q;

    wh_update_ctl #(.CW(CW)) u_upd (
        .clk        (clk),
        .rst        (rst),
        .upd_set    (upd_req),
        .period_end (period_end),
        .cfg_hi     (cfg_wait),
        .cfg_lo     (cfg_hold),
        .act_hi     (act_hi),
        .act_lo     (act_lo),
        .busy       (upd_busy)
    );

    wh_phase_gen #(.CW(CW)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (enable),
        .act_hi     (act_hi),
        .act_lo     (act_lo),
        .period_end (period_end),
        .div_q      (div_q)
    );

    wh_bypass_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .bypass  (bypass),
        .en      (enable),
        .div_q   (div_q),
        .clk_out (clk_out)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!upd_busy && (act_hi == '0) && (act_lo == '0)));

endmodule

// File: tb/tb_wh_clk_div.sv
module tb_wh_clk_div;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [3:0] w_wait = '0, w_hold = '0;
    logic [2:0] n_wait = '0, n_hold = '0;
    logic w_byp = 0, n_byp = 0, w_upd = 0, n_upd = 0, w_en = 0, n_en = 0;
    logic w_out, n_out, w_busy, n_busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    wh_clk_div #(.CW(4)) dut (
        .clk(clk), .rst(rst), .cfg_wait(w_wait), .cfg_hold(w_hold),
        .bypass(w_byp), .upd_req(w_upd), .enable(w_en),
        .clk_out(w_out), .upd_busy(w_busy)
    );

    wh_clk_div #(.CW(3)) dut_narrow (
        .clk(clk), .rst(rst), .cfg_wait(n_wait), .cfg_hold(n_hold),
        .bypass(n_byp), .upd_req(n_upd), .enable(n_en),
        .clk_out(n_out), .upd_busy(n_busy)
    );

    function automatic int exp_wait(int r);  return r / 2 - 1;             endfunction
    function automatic int exp_hold(int r);  return r - exp_wait(r) - 2;   endfunction
    function automatic bit get_out(int sel);  return sel == 0 ? w_out  : n_out;  endfunction
    function automatic bit get_busy(int sel); return sel == 0 ? w_busy : n_busy; endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int sel, int wv, int hv);
        if (sel == 0) begin w_wait <= 4'(wv); w_hold <= 4'(hv); end
        else          begin n_wait <= 3'(wv); n_hold <= 3'(hv); end
    endtask

    task automatic set_upd(int sel, bit v);
        if (sel == 0) w_upd <= v; else n_upd <= v;
    endtask

    task automatic set_en(int sel, bit v);
        if (sel == 0) w_en <= v; else n_en <= v;
    endtask

    // Count high then low samples starting at the current negedge sample.
    task automatic count_run(int sel, output int hi, output int lo);
        hi = 0; lo = 0;
        for (int g = 0; g < 80; g++) begin
            if (!get_out(sel)) break;
            hi++; @(negedge clk);
        end
        for (int g = 0; g < 80; g++) begin
            if (get_out(sel)) break;
            lo++; @(negedge clk);
        end
    endtask

    task automatic sync_rise(int sel);
        @(negedge clk);
        for (int g = 0; g < 80 && get_out(sel); g++) @(negedge clk);
        for (int g = 0; g < 80 && !get_out(sel); g++) @(negedge clk);
    endtask

    task automatic measure(int sel, output int hi, output int lo);
        sync_rise(sel);
        count_run(sel, hi, lo);
    endtask

    // Load ratio r with the handshake and check the timing it produces.
    task automatic program_ratio(int sel, int r);
        int hi, lo, g;
        bit prev;
        set_cfg(sel, exp_wait(r), exp_hold(r));
        sync_rise(sel);
        set_upd(sel, 1'b1);
        @(negedge clk);
        set_upd(sel, 1'b0);
        check(get_busy(sel) == 1'b1, "R5", "busy after request", get_busy(sel), 1);
        prev = get_out(sel);
        for (g = 0; g < 80 && get_busy(sel); g++) begin
            prev = get_out(sel);
            @(negedge clk);
        end
        check(prev == 1'b0, "R6", "output before apply", prev, 0);
        check(get_out(sel) == 1'b1, "R6", "high starts at apply", get_out(sel), 1);
        count_run(sel, hi, lo);
        check(hi == exp_wait(r) + 1, "R2", $sformatf("high run ratio %0d", r), hi, exp_wait(r) + 1);
        check(lo == exp_hold(r) + 1, "R2", $sformatf("low run ratio %0d", r), lo, exp_hold(r) + 1);
        check(hi + lo == r, "R3", $sformatf("period ratio %0d", r), hi + lo, r);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi, lo, r, seed;
        seed = $urandom(32'h1d2c);
        repeat (4) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R1: reset state
        check(w_out == 1'b0, "R1", "wide output after reset", w_out, 0);
        check(w_busy == 1'b0, "R1", "wide busy after reset", w_busy, 0);
        check(n_busy == 1'b0, "R1", "narrow busy after reset", n_busy, 0);
        // R4: counts changed without request -> reset ratio 2 remains
        set_cfg(0, 9, 9);
        set_cfg(1, 5, 5);
        w_en <= 1'b1; n_en <= 1'b1;
        measure(0, hi, lo);
        check(hi == 1 && lo == 1, "R1", "reset ratio high", hi, 1);
        check(lo == 1, "R4", "wide low unchanged without request", lo, 1);
        measure(1, hi, lo);
        check(hi == 1 && lo == 1, "R4", "narrow period unchanged without request", hi + lo, 2);

        // Directed: odd ratio asymmetry (R3)
        program_ratio(0, 7);
        measure(0, hi, lo);
        check(lo - hi == 1, "R3", "odd ratio low minus high", lo - hi, 1);
        // R4 again at a non-default ratio
        set_cfg(0, 1, 12);
        measure(0, hi, lo);
        check(hi == 3 && lo == 4, "R4", "ratio 7 kept without request", hi * 10 + lo, 34);

        // R9: extremes of both variants
        program_ratio(0, 2);
        program_ratio(0, 32);
        program_ratio(1, 16);
        program_ratio(1, 2);
        measure(1, hi, lo);
        check(hi + lo == 2, "R9", "narrow min ratio", hi + lo, 2);

        // Random ratios across each range
        for (int i = 0; i < 12; i++) begin
            r = 2 + int'($urandom_range(30));
            program_ratio(0, r);
            r = 2 + int'($urandom_range(14));
            program_ratio(1, r);
        end

        // R7: disable during high phase, then re-enable
        program_ratio(0, 6);
        sync_rise(0);
        w_en <= 1'b0;
        count_run(0, hi, lo);
        check(hi == 3, "R7", "high completes after disable", hi, 3);
        check(lo >= 40, "R7", "output parked low", lo, 40);
        w_en <= 1'b1;
        @(negedge clk);
        check(w_out == 1'b1, "R7", "high one edge after re-enable", w_out, 1);
        count_run(0, hi, lo);
        check(hi == 3 && lo == 3, "R7", "period after re-enable", hi * 10 + lo, 33);

        // R8: bypass follows input clock, gated by enable
        @(posedge clk); #2;
        w_byp <= 1'b1;
        n_byp <= 1'b1;
        @(posedge clk); #1;
        check(w_out == 1'b1, "R8", "bypass high with clock", w_out, 1);
        check(n_out == 1'b1, "R8", "narrow bypass high with clock", n_out, 1);
        @(negedge clk); #1;
        check(w_out == 1'b0, "R8", "bypass low with clock", w_out, 0);
        @(posedge clk); #2;
        w_en <= 1'b0;
        @(negedge clk); #1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check(w_out == 1'b0, "R8", "bypass gated off", w_out, 0);
        end
        w_en <= 1'b1;
        @(posedge clk); #2;
        w_byp <= 1'b0;
        n_byp <= 1'b0;
        measure(0, hi, lo);
        check(hi == 3 && lo == 3, "R2", "divider resumes after bypass", hi * 10 + lo, 33);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule